// File: doc/BRIEF.md
# Auto-Rate Manchester Bit Decoder

This block turns a Manchester-coded serial line into a stream of decoded bits without being told the bit rate. Every accepted transition is time-stamped against the local sampling clock. The block then compares the spacing of successive transitions to tell half-bit gaps from full-bit gaps. From a short run of those gaps it estimates the half-bit period. Once it has that estimate it locks and starts decoding bits.

Decoding works by clock recovery. Edges that fall on bit boundaries are blanked out, and each mid-bit edge yields one bit with a one-clock strobe. An extra-long gap of one and a half bits serves as a phase marker. A line that stays quiet for several bit periods throws away the learned rate. After that, a following stream can be acquired at a rate that differs by a factor of ten or more, using the same sampling clock.

The input is expected to be already synchronised to `clk`. Framing above the bit level is left to the consumer of `bit_out`/`bit_valid`.

Top module: `manch_autorate`

## Requirements
- R1: After reset, `locked`, `bit_valid`, `bit_out` and `half_period` are all 0.
- R2: On lock, `half_period` equals the truncated mean of the 8 learning samples, in sampling clocks. A short gap contributes its own length and a long gap contributes half its length. The value does not change while `locked` stays high.
- R3: Learning counts gaps against a reference short gap. A "same" gap is 0.75 to 1.25 times the reference. A "double" gap is 1.5 to 2.5 times the reference. Lock needs 8 consecutive gaps in these classes, with at least one of each class. An unbroken run of equal bits therefore never locks. The first edge after reset or after an idle timeout only starts timing.
- R4: A gap that fits neither class, and is not a reference that turns out to be a long gap, restarts learning from that gap. A line alternating gaps in a 1:3 ratio never locks.
- R5: The level after a mid-bit edge is the bit value: a rising mid-bit edge gives 1 and a falling one gives 0, and the first half of each bit carries the complement. `bit_valid` is high for exactly one clock per decoded bit, and bits come out in line order.
- R6: An edge arriving less than 1.5 half-periods after the last mid-bit edge is a boundary edge and yields no bit. Runs of identical bits and runs of alternating bits decode to exactly one bit per bit sent.
- R7: A gap of 2.5 to 3.5 half-periods is a preamble. It yields no bit, and its trailing edge is taken as a bit boundary, so the next data bit's mid-bit edge follows one half-period later. A gap longer than 3.5 half-periods drops phase alignment. After lock, decoding starts at the first long gap or preamble.
- R8: `bit_valid` is never high while `locked` is low.
- R9: While locked, a line with no accepted edge for 8 half-periods (4 bit periods) drops `locked` and clears `half_period` to 0. A following stream at a ten-times different rate locks to its own period. While unlocked, the timeout is the 16-bit gap counter saturating at 65535. Gaps shorter than 2 clocks are ignored as glitches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Synchronised Manchester line |
| bit_out | output | 1 | Most recent decoded bit |
| bit_valid | output | 1 | One-clock strobe per decoded bit |
| locked | output | 1 | Rate learned, decoding active |
| half_period | output | 16 | Learned half-bit period in clocks, 0 when unlocked |

## Verification
Two events can land on the same transition. One is the gap that completes learning and raises `locked`. The other is the gap that the bit recoverer would need to establish phase. The learner consumes that final gap, and the recoverer is not yet locked when it arrives, so it ignores the gap. The recoverer then waits for a long gap or a preamble before producing bits.

The bench provokes this collision on every stream. It keeps sending a training pattern past the lock point and then sends a preamble. It judges the result by requiring exactly the payload bits, in order, to follow the preamble. It also requires that no strobe ever appears outside lock.

A second collision is between the idle timeout and a late edge. The bench checks that lock survives seven half-periods of quiet and is gone after eleven.

// File: rtl/manch_pkg.sv
// Shared widths and types for the auto-rate Manchester decoder.
package manch_pkg;
    parameter int unsigned IVL_W = 16;

    typedef logic [IVL_W-1:0] ivl_t;

    // One accepted line transition as seen by the downstream stages.
    typedef struct packed {
        logic valid;   // an interval is reported this cycle
        logic level;   // line level after the transition
        ivl_t len;     // clocks since the previous accepted transition
    } edge_ev_t;

    // How a new interval relates to the reference short interval.
    typedef enum logic [1:0] {
        CL_SAME = 2'd0,
        CL_DBL  = 2'd1,
        CL_HALF = 2'd2,
        CL_NONE = 2'd3
    } ivl_class_t;
endpackage

// File: rtl/manch_edge_timer.sv
// Edge timer: detects transitions on the synchronised line and reports the
// number of clocks since the previous accepted transition. Assumes line_in
// is already synchronous to clk. Gaps shorter than MIN_IVL are treated as
// glitches and neither reported nor allowed to restart timing. The first
// edge after reset or after an idle timeout only starts timing. The counter
// saturates at its maximum. idle_hit pulses once when the gap reaches
// idle_lim.
module manch_edge_timer
    import manch_pkg::*;
#(
    parameter int unsigned MIN_IVL = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_in,
    input  ivl_t     idle_lim,
    output edge_ev_t ev,
    output logic     idle_hit
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam ivl_t CNT_MAX = '1;
    localparam ivl_t MIN_LEN = ivl_t'(MIN_IVL);

    logic line_q;
    ivl_t cnt;
    logic have_prev;
    logic idle_done;
    logic line_edge;
    logic glitch;

    // Transition and glitch qualification.
    always_comb begin
        line_edge = line_in ^ line_q;
        glitch    = have_prev && (cnt < MIN_LEN);
    end

    // Gap counting, event emission and idle detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            cnt       <= '0;
            have_prev <= 1'b0;
            idle_done <= 1'b1;
            ev        <= '0;
            idle_hit  <= 1'b0;
        end else begin
            line_q   <= line_in;
            ev.valid <= 1'b0;
            idle_hit <= 1'b0;
            if (line_edge && !glitch) begin
                ev.valid  <= have_prev;
                ev.len    <= cnt;
                ev.level  <= line_in;
                cnt       <= ivl_t'(1);
                have_prev <= 1'b1;
                idle_done <= 1'b0;
            end else begin
                if (cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
                if (!idle_done && (cnt >= idle_lim)) begin
                    idle_hit  <= 1'b1;
                    idle_done <= 1'b1;
                    have_prev <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/manch_rate_learn.sv
// Rate learner: classifies each reported gap against a reference short gap
// as same (0.75x-1.25x), double (1.5x-2.5x) or half (reference was a long
// gap). After LEARN_N consecutive same/double gaps that include both kinds,
// it locks and publishes the mean half-bit period. A mixed window is
// required because a run of equal bits alone is ambiguous in rate. Assumes
// LEARN_N is a power of two. idle_hit clears everything.
module manch_rate_learn
    import manch_pkg::*;
#(
    parameter int unsigned LEARN_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_valid,
    input  ivl_t ev_len,
    input  logic idle_hit,
    output logic locked,
    output ivl_t half_per
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned LOG_N = $clog2(LEARN_N);
    localparam int unsigned SUM_W = IVL_W + LOG_N;
    localparam int unsigned N_W   = LOG_N + 1;
    localparam int unsigned CMP_W = IVL_W + 3;

    typedef logic [SUM_W-1:0] sum_t;
    typedef logic [N_W-1:0]   num_t;
    typedef logic [CMP_W-1:0] cmp_t;

    ivl_t       ref_len;
    sum_t       sum;
    num_t       n_seen;
    logic       seen_s;
    logic       seen_l;

    cmp_t       l1, l2, l3, l4, l5, r2, r3, r5;
    ivl_class_t cls;
    ivl_t       sample;
    sum_t       sum_next;
    num_t       n_next;
    logic       seen_s_next;
    logic       seen_l_next;

    // Scaled copies of the new gap and the reference for ratio tests.
    always_comb begin
        l1 = cmp_t'(ev_len);
        l2 = l1 << 1;
        l3 = l2 + l1;
        l4 = l1 << 2;
        l5 = l4 + l1;
        r2 = cmp_t'(ref_len) << 1;
        r3 = r2 + cmp_t'(ref_len);
        r5 = (cmp_t'(ref_len) << 2) + cmp_t'(ref_len);
    end

    // Classify the gap relative to the reference.
    always_comb begin
        if ((l4 >= r3) && (l4 <= r5)) begin
            cls = CL_SAME;
        end else if ((l2 >= r3) && (l2 <= r5)) begin
            cls = CL_DBL;
        end else if ((r2 >= l3) && (r2 <= l5)) begin
            cls = CL_HALF;
        end else begin
            cls = CL_NONE;
        end
    end

    // Half-bit sample and running totals for an accepted gap.
    always_comb begin
        sample      = (cls == CL_DBL) ? (ev_len >> 1) : ev_len;
        sum_next    = sum + sum_t'(sample);
        n_next      = n_seen + 1'b1;
        seen_s_next = seen_s | (cls == CL_SAME);
        seen_l_next = seen_l | (cls == CL_DBL);
    end

    // Learning state machine and lock register.
    always_ff @(posedge clk) begin
        if (!rst_n || idle_hit) begin
            ref_len  <= '0;
            sum      <= '0;
            n_seen   <= '0;
            seen_s   <= 1'b0;
            seen_l   <= 1'b0;
            locked   <= 1'b0;
            half_per <= '0;
        end else if (ev_valid && !locked) begin
            if (ref_len == '0) begin
                ref_len <= ev_len;
                sum     <= sum_t'(ev_len);
                n_seen  <= num_t'(1);
                seen_s  <= 1'b1;
                seen_l  <= 1'b0;
            end else begin
                case (cls)
                    CL_SAME, CL_DBL: begin
                        if (n_next == num_t'(LEARN_N)) begin
                            if (seen_s_next && seen_l_next) begin
                                locked   <= 1'b1;
                                half_per <= ivl_t'(sum_next >> LOG_N);
                            end
                            sum    <= '0;
                            n_seen <= '0;
                            seen_s <= 1'b0;
                            seen_l <= 1'b0;
                        end else begin
                            sum    <= sum_next;
                            n_seen <= n_next;
                            seen_s <= seen_s_next;
                            seen_l <= seen_l_next;
                        end
                    end
                    CL_HALF: begin
                        ref_len <= ev_len;
                        sum     <= sum_t'(ev_len);
                        n_seen  <= num_t'(1);
                        seen_s  <= 1'b1;
                        seen_l  <= 1'b1;
                    end
                    default: begin
                        ref_len <= ev_len;
                        sum     <= sum_t'(ev_len);
                        n_seen  <= num_t'(1);
                        seen_s  <= 1'b1;
                        seen_l  <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/manch_bit_recover.sv
// Bit recoverer: while locked, accumulates gaps since the last mid-bit edge.
// Edges inside a blanking window of 1.5 half-periods are bit boundaries.
// The first edge at or beyond the window is a mid-bit edge, and the line
// level after it is the decoded bit. A gap of 2.5-3.5 half-periods is a
// preamble whose trailing edge is a bit boundary. Longer gaps drop
// alignment. Until aligned, only a long gap or a preamble establishes phase.
module manch_bit_recover
    import manch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  edge_ev_t ev,
    input  logic     locked,
    input  ivl_t     half_per,
    output logic     bit_out,
    output logic     bit_valid
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned ACC_W = IVL_W + 2;
    localparam int unsigned CMP_W = IVL_W + 3;

    typedef logic [ACC_W-1:0] acc_t;
    typedef logic [CMP_W-1:0] cmp_t;

    logic aligned;
    acc_t acc;
    acc_t half_x;
    acc_t blank;
    acc_t len_x;
    acc_t acc_sum;
    cmp_t len2;
    cmp_t hp5;
    cmp_t hp7;
    logic is_pre;
    logic is_lost;

    // Blanking window and preamble band derived from the learned period.
    always_comb begin
        half_x  = acc_t'(half_per);
        blank   = half_x + (half_x >> 1);
        len_x   = acc_t'(ev.len);
        acc_sum = acc + len_x;
        len2    = cmp_t'(ev.len) << 1;
        hp5     = (cmp_t'(half_per) << 2) + cmp_t'(half_per);
        hp7     = (cmp_t'(half_per) << 3) - cmp_t'(half_per);
        is_pre  = (len2 >= hp5) && (len2 <= hp7);
        is_lost = (len2 > hp7);
    end

    // Phase tracking and bit emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned   <= 1'b0;
            acc       <= '0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            if (!locked) begin
                aligned <= 1'b0;
                acc     <= '0;
            end else if (ev.valid) begin
                if (is_pre) begin
                    aligned <= 1'b1;
                    acc     <= half_x;
                end else if (is_lost) begin
                    aligned <= 1'b0;
                    acc     <= '0;
                end else if (!aligned) begin
                    if (len_x >= blank) begin
                        bit_out   <= ev.level;
                        bit_valid <= 1'b1;
                        aligned   <= 1'b1;
                        acc       <= '0;
                    end
                end else if (acc_sum >= blank) begin
                    bit_out   <= ev.level;
                    bit_valid <= 1'b1;
                    acc       <= '0;
                end else begin
                    acc <= acc_sum;
                end
            end
        end
    end
endmodule

// File: rtl/manch_autorate.sv
// Top level of the auto-rate Manchester decoder. Wires the edge timer, rate
// learner and bit recoverer, and derives the idle limit. While locked the
// limit is IDLE_BITS bit periods, saturated to the counter width. While
// unlocked it is the counter's saturation value.
module manch_autorate
    import manch_pkg::*;
#(
    parameter int unsigned LEARN_N   = 8,
    parameter int unsigned MIN_IVL   = 2,
    parameter int unsigned IDLE_BITS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_in,
    output logic                      bit_out,
    output logic                      bit_valid,
    output logic                      locked,
    output logic [manch_pkg::IVL_W-1:0] half_period
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned IDLE_HALVES = 2 * IDLE_BITS;
    localparam int unsigned LIM_W       = IVL_W + $clog2(IDLE_HALVES + 1);

    typedef logic [LIM_W-1:0] lim_t;

    edge_ev_t ev;
    logic     idle_hit;
    ivl_t     idle_lim;
    lim_t     lim_full;

    // Idle limit: a multiple of the learned period, or counter saturation.
    always_comb begin
        lim_full = lim_t'(half_period) * lim_t'(IDLE_HALVES);
        if (!locked || (lim_full > lim_t'({IVL_W{1'b1}}))) begin
            idle_lim = '1;
        end else begin
            idle_lim = ivl_t'(lim_full);
        end
    end

    manch_edge_timer #(
        .MIN_IVL (MIN_IVL)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .idle_lim (idle_lim),
        .ev       (ev),
        .idle_hit (idle_hit)
    );

    manch_rate_learn #(
        .LEARN_N (LEARN_N)
    ) u_learn (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev.valid),
        .ev_len   (ev.len),
        .idle_hit (idle_hit),
        .locked   (locked),
        .half_per (half_period)
    );

    manch_bit_recover u_recover (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .locked    (locked),
        .half_per  (half_period),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );
endmodule

// File: rtl/manch_autorate_chk.sv
// Property checker for manch_autorate, attached through bind.
module manch_autorate_chk
    import manch_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic locked,
    input ivl_t half_period
);
    timeunit 1ns;
    timeprecision 100ps;

    // R8: strobes appear only while locked.
    p_valid_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> locked);

    // R5: each decoded bit is a single-clock strobe.
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R2: learned period holds steady through a lock.
    p_half_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(half_period));

    // R9: no period is published while unlocked.
    p_unlock_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (half_period == '0));

    // R3: a lock always comes with a nonzero period.
    p_lock_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (half_period != '0));
endmodule

bind manch_autorate manch_autorate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .locked      (locked),
    .half_period (half_period)
);

// File: tb/manch_autorate_bench.sv
// Self-checking bench: directed streams at two rates a decade apart, equal
// and alternating payloads, non-locking patterns, and seeded random streams.
module manch_autorate_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b0;
    logic        bit_out;
    logic        bit_valid;
    logic        locked;
    logic [15:0] half_period;

    int   n_chk = 0;
    int   n_bad = 0;
    int   viol = 0;
    int   dbl = 0;
    logic prev_v = 1'b0;
    logic capture = 1'b0;
    int   got[$];
    bit   payload[64];

    always #2.5 clk = ~clk;

    manch_autorate u_manch_autorate (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .bit_out     (bit_out),
        .bit_valid   (bit_valid),
        .locked      (locked),
        .half_period (half_period)
    );

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (bit_valid && !locked) viol++;
        if (bit_valid && prev_v) dbl++;
        prev_v = bit_valid;
        if (bit_valid && capture) got.push_back(int'(bit_out));
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    // Mean of the training window: 1100 pattern gives short,short,long.
    function automatic int exp_half(int h);
        int s = 0;
        for (int k = 0; k < 8; k++) s += (k % 3 == 2) ? (2 * h) / 2 : h;
        return s / 8;
    endfunction

    task automatic send_bit(bit b, int h);
        line_in = ~b;
        hold(h);
        line_in = b;
        hold(h);
    endtask

    // mode 0 random, 1 all ones, 2 alternating.
    task automatic run_stream(int h, int nb, int mode);
        int mism = 0;
        line_in = 1'b0;
        hold(12 * h);
        for (int k = 0; k < 16; k++) send_bit(k % 4 < 2, h);
        check("R3 lock after mixed training", int'(locked), 1);
        check("R2 learned half period", int'(half_period), exp_half(h));
        payload[0] = 1'b1;
        for (int i = 1; i < nb; i++) begin
            case (mode)
                1: payload[i] = 1'b1;
                2: payload[i] = (i % 2 == 0);
                default: payload[i] = bit'($urandom % 2);
            endcase
        end
        got.delete();
        line_in = 1'b1;
        hold(3 * h);
        line_in = 1'b0;
        capture = 1'b1;
        for (int i = 0; i < nb; i++) send_bit(payload[i], h);
        hold(6 * h);
        capture = 1'b0;
        check("R6 R7 bit count after preamble", got.size(), nb);
        for (int i = 0; i < nb && i < got.size(); i++)
            if (got[i] != int'(payload[i])) mism++;
        check("R5 decoded bit values", mism, 0);
        check("R9 lock held before timeout", int'(locked), 1);
        hold(4 * h + 4);
        check("R9 lock dropped after idle", int'(locked), 0);
        check("R9 period cleared after idle", int'(half_period), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        hold(4);
        rst_n = 1'b1;
        hold(1);
        check("R1 reset locked", int'(locked), 0);
        check("R1 reset bit_valid", int'(bit_valid), 0);
        check("R1 reset half_period", int'(half_period), 0);
        check("R1 reset bit_out", int'(bit_out), 0);

        run_stream(8, 32, 0);
        run_stream(80, 32, 0);
        run_stream(20, 40, 1);
        run_stream(12, 40, 2);

        // R3: identical bits only, never locks.
        line_in = 1'b0;
        hold(120);
        for (int k = 0; k < 30; k++) send_bit(1'b1, 10);
        check("R3 equal-bit run stays unlocked", int'(locked), 0);
        check("R3 equal-bit run no period", int'(half_period), 0);

        // R4: 1:3 gap alternation, never locks.
        for (int k = 0; k < 24; k++) begin
            line_in = ~line_in;
            hold((k % 2 == 1) ? 30 : 10);
        end
        check("R4 out-of-band ratio stays unlocked", int'(locked), 0);

        for (int s = 0; s < 4; s++) begin
            int h = 6 + int'($urandom % 55);
            int nb = 16 + int'($urandom % 48);
            run_stream(h, nb, 0);
        end

        check("R8 no strobe while unlocked", viol, 0);
        check("R5 strobes one clock wide", dbl, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule